// File: doc/BRIEF.md
# Processor exception entry unit

This unit performs the state save and redirect that a 32-bit RISC core needs on entering an exception handler. The core presents a request made of a type code, a 32-bit flags word and a 32-bit address argument. Alongside it the core supplies the current program counter, the sequential next program counter and the present machine state register value. The unit decides in the same cycle whether the type code is one it handles and answers with an accept or a reject strobe.

An accepted request commits on the clock edge where valid is high. The return address goes into save/restore register 0 and a masked copy of the machine state goes into save/restore register 1. Which return address is saved, and how the state is masked and merged, depends on the exception type. Data storage faults also record the faulting address and the fault status word.

In the cycle after acceptance the unit emits one-cycle pulses that tell the core to:
- clear its machine state register,
- fetch from the vector address, which equals the type code,
- invalidate its translation buffers.

Two diagnostic pulses flag suspicious entries: an instruction storage fault taken at address zero, and a machine check taken while machine-check handling was disabled.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, the save/restore registers, the fault address register and the fault status register are zero, and every output pulse (redirect_valid, tlb_inv, msr_clr, isi_pc0_warn, mchk_me_err) is low.
- R2: The recognised type codes are 0x200 machine check, 0x300 data storage, 0x400 instruction storage, 0x500 external, 0x700 program, 0x800 FPU unavailable, 0x900 decrementer, 0xC00 system call, 0xD00 trace, 0xE00 FP assist and 0xF20 vector unavailable, compared over all 32 bits. For a recognised type with no special rule (0x500, 0x800, 0x900, 0xD00, 0xE00), save/restore register 0 takes cur_pc and save/restore register 1 takes msr AND 0x87C0FFFF.
- R3: For system call (0xC00), save/restore register 0 takes next_pc, and save/restore register 1 takes msr AND 0x87C0FFFF.
- R4: For program (0x700), save/restore register 0 takes next_pc when flags bit 16 is 1 and cur_pc otherwise. Save/restore register 1 takes (msr AND 0x87C0FFFF) OR flags.
- R5: For instruction storage (0x400), save/restore register 0 takes cur_pc and save/restore register 1 takes (msr AND 0x87C0FFFF) OR flags. isi_pc0_warn pulses for one cycle after acceptance if cur_pc was zero, and stays low otherwise.
- R6: For data storage (0x300), the fault address register takes arg, the fault status register takes flags and save/restore register 1 takes msr AND 0x87C0FFFF. Every other type leaves both fault registers unchanged.
- R7: For vector unavailable (0xF20), save/restore register 1 takes msr AND 0x0000FF73.
- R8: For machine check (0x200), save/restore register 1 takes (msr AND 0x87C0FFFF) with bit 1 forced to 1. mchk_me_err pulses for one cycle after acceptance if msr bit 12 was 0, and stays low otherwise.
- R9: In the cycle after an acceptance, redirect_valid, tlb_inv and msr_clr are high for exactly one cycle, and redirect_pc equals the accepted type code.
- R10: A valid request with an unrecognised type code raises req_reject and not req_accept in the same cycle. It changes no register and produces no pulse.
- R11: req_accept is high exactly when req_valid is high and the type is recognised. Without req_valid, nothing changes and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request present |
| req_type | input | 32 | Exception type code, also the vector address |
| req_flags | input | 32 | Type-specific flags word |
| req_arg | input | 32 | Address argument (faulting data address) |
| cur_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the sequentially next instruction |
| msr | input | 32 | Current machine state register value |
| req_accept | output | 1 | Request accepted this cycle |
| req_reject | output | 1 | Request rejected this cycle (unknown type) |
| srr0 | output | 32 | Saved return address |
| srr1 | output | 32 | Saved machine state |
| dar | output | 32 | Faulting data address |
| dsisr | output | 32 | Data storage fault status |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Vector address for the redirect |
| tlb_inv | output | 1 | Translation buffer invalidate pulse |
| msr_clr | output | 1 | Machine state clear pulse |
| isi_pc0_warn | output | 1 | Instruction storage fault taken at address zero |
| mchk_me_err | output | 1 | Machine check taken with checks disabled |

## Verification
The type decoder is swept over every multiple of 0x10 up to 0xFFF, and codes that match in the low bits but carry upper bits are also tried. A decoder that looks only at part of the code would accept an alias or drop a vector. Each type is driven with several machine state patterns and with the program type's next bit both set and clear. A wrong mask, a missing OR of the flags, or a wrong return address choice shows up as a mismatch in a saved register. The bench checks that rejected requests and non-data-storage types leave the fault registers untouched, and that the diagnostic pulses fire only on their exact conditions. A design that updated state on a reject, or raised a warning at a non-zero address, would be caught.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN = 32;

    localparam logic [XLEN-1:0] VEC_MCHK  = 32'h0000_0200;
    localparam logic [XLEN-1:0] VEC_DSTOR = 32'h0000_0300;
    localparam logic [XLEN-1:0] VEC_ISTOR = 32'h0000_0400;
    localparam logic [XLEN-1:0] VEC_EXT   = 32'h0000_0500;
    localparam logic [XLEN-1:0] VEC_PROG  = 32'h0000_0700;
    localparam logic [XLEN-1:0] VEC_NOFPU = 32'h0000_0800;
    localparam logic [XLEN-1:0] VEC_DECR  = 32'h0000_0900;
    localparam logic [XLEN-1:0] VEC_SCALL = 32'h0000_0C00;
    localparam logic [XLEN-1:0] VEC_TRACE = 32'h0000_0D00;
    localparam logic [XLEN-1:0] VEC_FPAST = 32'h0000_0E00;
    localparam logic [XLEN-1:0] VEC_NOVEC = 32'h0000_0F20;

    // How each recognised type shapes the saved state
    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_PLAIN,
        CLS_SCALL,
        CLS_PROG,
        CLS_ISTOR,
        CLS_DSTOR,
        CLS_NOVEC,
        CLS_MCHK
    } exc_cls_e;

    typedef struct packed {
        logic [XLEN-1:0] srr0;
        logic [XLEN-1:0] srr1;
        logic [XLEN-1:0] dar;
        logic [XLEN-1:0] dsisr;
        logic [XLEN-1:0] redir_pc;
        logic            redir_vld;
        logic            tlb_inv;
        logic            msr_clr;
        logic            pc0_warn;
        logic            me_err;
    } exc_state_t;

endpackage

// File: rtl/exc_type_decode.sv
module exc_type_decode
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0] type_code,
    output exc_cls_e        cls,
    output logic            known
);

    always_comb begin
        case (type_code)
            VEC_MCHK:  cls = CLS_MCHK;
            VEC_DSTOR: cls = CLS_DSTOR;
            VEC_ISTOR: cls = CLS_ISTOR;
            VEC_PROG:  cls = CLS_PROG;
            VEC_SCALL: cls = CLS_SCALL;
            VEC_NOVEC: cls = CLS_NOVEC;
            VEC_EXT,
            VEC_NOFPU,
            VEC_DECR,
            VEC_TRACE,
            VEC_FPAST: cls = CLS_PLAIN;
            default:   cls = CLS_NONE;
        endcase
        known = (cls != CLS_NONE);
    end

endmodule

// File: rtl/exc_state_compose.sv
module exc_state_compose
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] MASK_STD      = 32'h87C0_FFFF,
    parameter logic [XLEN-1:0] MASK_VEC      = 32'h0000_FF73,
    parameter int              RI_BIT        = 1,
    parameter int              ME_BIT        = 12,
    parameter int              PROG_NEXT_BIT = 16
) (
    input  exc_cls_e        cls,
    input  logic [XLEN-1:0] flags,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] next_pc,
    input  logic [XLEN-1:0] msr,
    output logic [XLEN-1:0] ret_addr,
    output logic [XLEN-1:0] saved_msr,
    output logic            load_fault,
    output logic            pc0_hit,
    output logic            me_off
);

    localparam logic [XLEN-1:0] RI_ONE = XLEN'(1) << RI_BIT;

    logic [XLEN-1:0] masked_std;
    logic            use_next;

    assign masked_std = msr & MASK_STD;

    always_comb begin
        use_next = 1'b0;
        case (cls)
            CLS_SCALL: use_next = 1'b1;
            CLS_PROG:  use_next = flags[PROG_NEXT_BIT];
            default:   use_next = 1'b0;
        endcase
        ret_addr = use_next ? next_pc : cur_pc;
    end

    always_comb begin
        case (cls)
            CLS_PROG,
            CLS_ISTOR: saved_msr = masked_std | flags;
            CLS_NOVEC: saved_msr = msr & MASK_VEC;
            CLS_MCHK:  saved_msr = masked_std | RI_ONE;
            default:   saved_msr = masked_std;
        endcase
    end

    assign load_fault = (cls == CLS_DSTOR);
    assign pc0_hit    = (cls == CLS_ISTOR) && (cur_pc == '0);
    assign me_off     = (cls == CLS_MCHK) && !msr[ME_BIT];

endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs
    import exc_entry_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [XLEN-1:0] vec,
    input  logic [XLEN-1:0] ret_addr,
    input  logic [XLEN-1:0] saved_msr,
    input  logic            load_fault,
    input  logic [XLEN-1:0] fault_addr,
    input  logic [XLEN-1:0] fault_stat,
    input  logic            pc0_hit,
    input  logic            me_off,
    output exc_state_t      state
);

    exc_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.redir_vld = 1'b0;
        st_d.tlb_inv   = 1'b0;
        st_d.msr_clr   = 1'b0;
        st_d.pc0_warn  = 1'b0;
        st_d.me_err    = 1'b0;
        if (take) begin
            st_d.srr0      = ret_addr;
            st_d.srr1      = saved_msr;
            st_d.redir_pc  = vec;
            st_d.redir_vld = 1'b1;
            st_d.tlb_inv   = 1'b1;
            st_d.msr_clr   = 1'b1;
            st_d.pc0_warn  = pc0_hit;
            st_d.me_err    = me_off;
            if (load_fault) begin
                st_d.dar   = fault_addr;
                st_d.dsisr = fault_stat;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state = st_q;

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] MASK_STD      = 32'h87C0_FFFF,
    parameter logic [XLEN-1:0] MASK_VEC      = 32'h0000_FF73,
    parameter int              RI_BIT        = 1,
    parameter int              ME_BIT        = 12,
    parameter int              PROG_NEXT_BIT = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [XLEN-1:0] req_type,
    input  logic [XLEN-1:0] req_flags,
    input  logic [XLEN-1:0] req_arg,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] next_pc,
    input  logic [XLEN-1:0] msr,
    output logic            req_accept,
    output logic            req_reject,
    output logic [XLEN-1:0] srr0,
    output logic [XLEN-1:0] srr1,
    output logic [XLEN-1:0] dar,
    output logic [XLEN-1:0] dsisr,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            tlb_inv,
    output logic            msr_clr,
    output logic            isi_pc0_warn,
    output logic            mchk_me_err
);

    exc_cls_e        cls;
    logic            known;
    logic [XLEN-1:0] ret_addr;
    logic [XLEN-1:0] saved_msr;
    logic            load_fault;
    logic            pc0_hit;
    logic            me_off;
    exc_state_t      state;

    exc_type_decode u_dec (
        .type_code (req_type),
        .cls       (cls),
        .known     (known)
    );

    exc_state_compose #(
        .MASK_STD      (MASK_STD),
        .MASK_VEC      (MASK_VEC),
        .RI_BIT        (RI_BIT),
        .ME_BIT        (ME_BIT),
        .PROG_NEXT_BIT (PROG_NEXT_BIT)
    ) u_comp (
        .cls        (cls),
        .flags      (req_flags),
        .cur_pc     (cur_pc),
        .next_pc    (next_pc),
        .msr        (msr),
        .ret_addr   (ret_addr),
        .saved_msr  (saved_msr),
        .load_fault (load_fault),
        .pc0_hit    (pc0_hit),
        .me_off     (me_off)
    );

    assign req_accept = req_valid && known;
    assign req_reject = req_valid && !known;

    exc_save_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (req_accept),
        .vec        (req_type),
        .ret_addr   (ret_addr),
        .saved_msr  (saved_msr),
        .load_fault (load_fault),
        .fault_addr (req_arg),
        .fault_stat (req_flags),
        .pc0_hit    (pc0_hit),
        .me_off     (me_off),
        .state      (state)
    );

    assign srr0           = state.srr0;
    assign srr1           = state.srr1;
    assign dar            = state.dar;
    assign dsisr          = state.dsisr;
    assign redirect_valid = state.redir_vld;
    assign redirect_pc    = state.redir_pc;
    assign tlb_inv        = state.tlb_inv;
    assign msr_clr        = state.msr_clr;
    assign isi_pc0_warn   = state.pc0_warn;
    assign mchk_me_err    = state.me_err;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [XLEN-1:0] req_type,
    input logic [XLEN-1:0] next_pc,
    input logic [XLEN-1:0] msr,
    input logic            req_accept,
    input logic            req_reject,
    input logic [XLEN-1:0] srr0,
    input logic [XLEN-1:0] srr1,
    input logic [XLEN-1:0] dar,
    input logic [XLEN-1:0] dsisr,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic            tlb_inv,
    input logic            msr_clr
);

    // R10, R11
    a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_accept && req_reject));

    a_r11_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept || req_reject) |-> req_valid);

    a_r9_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |=> (redirect_valid && tlb_inv && msr_clr));

    a_r9_vector: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |=> (redirect_pc == $past(req_type)));

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_accept |=> !(redirect_valid || tlb_inv || msr_clr));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |=> ($stable(srr0) && $stable(srr1) && $stable(dar) && $stable(dsisr)));

    a_r3_scall_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_type == VEC_SCALL) |=> (srr0 == $past(next_pc)));

    a_r8_ri_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_type == VEC_MCHK) |=> srr1[1]);

    a_r7_vec_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_type == VEC_NOVEC) |=> ((srr1 & ~32'h0000_FF73) == '0));

    a_r7_vec_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_type == VEC_NOVEC) |=> (srr1 == ($past(msr) & 32'h0000_FF73)));

endmodule

bind exc_entry_unit exc_entry_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_type       (req_type),
    .next_pc        (next_pc),
    .msr            (msr),
    .req_accept     (req_accept),
    .req_reject     (req_reject),
    .srr0           (srr0),
    .srr1           (srr1),
    .dar            (dar),
    .dsisr          (dsisr),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .tlb_inv        (tlb_inv),
    .msr_clr        (msr_clr)
);

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_type = '0;
    logic [31:0] req_flags = '0;
    logic [31:0] req_arg = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] next_pc = '0;
    logic [31:0] msr = '0;
    logic        req_accept, req_reject;
    logic [31:0] srr0, srr1, dar, dsisr, redirect_pc;
    logic        redirect_valid, tlb_inv, msr_clr, isi_pc0_warn, mchk_me_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] e_srr0 = '0, e_srr1 = '0, e_dar = '0, e_dsisr = '0;

    always #5 clk = ~clk;

    exc_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_flags(req_flags), .req_arg(req_arg), .cur_pc(cur_pc), .next_pc(next_pc),
        .msr(msr), .req_accept(req_accept), .req_reject(req_reject), .srr0(srr0),
        .srr1(srr1), .dar(dar), .dsisr(dsisr), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .tlb_inv(tlb_inv), .msr_clr(msr_clr),
        .isi_pc0_warn(isi_pc0_warn), .mchk_me_err(mchk_me_err)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%08h exp=%08h", req, act, exp);
        end
    endtask

    function automatic bit is_known(logic [31:0] t);
        return t == 32'h200 || t == 32'h300 || t == 32'h400 || t == 32'h500 ||
               t == 32'h700 || t == 32'h800 || t == 32'h900 || t == 32'hC00 ||
               t == 32'hD00 || t == 32'hE00 || t == 32'hF20;
    endfunction

    // One request: drive after a falling edge, check the handshake, then
    // check registers and pulses after the committing edge and once more
    // one cycle later when the pulses must have dropped.
    task automatic do_req(logic [31:0] t, logic [31:0] fl, logic [31:0] ar,
                          logic [31:0] pc, logic [31:0] npc, logic [31:0] m,
                          bit full);
        bit          k;
        logic [31:0] base;
        k = is_known(t);
        @(negedge clk);
        req_valid = 1'b1; req_type = t; req_flags = fl; req_arg = ar;
        cur_pc = pc; next_pc = npc; msr = m;
        #1;
        chk("R11 accept", {31'b0, req_accept}, {31'b0, k});
        chk("R10 reject", {31'b0, req_reject}, {31'b0, !k});
        if (k) begin
            base = m & 32'h87C0FFFF;
            e_srr0 = (t == 32'hC00 || (t == 32'h700 && fl[16])) ? npc : pc;
            if (t == 32'hF20)                      e_srr1 = m & 32'h0000FF73;
            else if (t == 32'h700 || t == 32'h400) e_srr1 = base | fl;
            else if (t == 32'h200)                 e_srr1 = base | 32'h2;
            else                                   e_srr1 = base;
            if (t == 32'h300) begin
                e_dar = ar; e_dsisr = fl;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (full || !k) begin
            chk("R2-type srr0", srr0, e_srr0);
            chk("R2-type srr1", srr1, e_srr1);
            chk("R6 dar", dar, e_dar);
            chk("R6 dsisr", dsisr, e_dsisr);
        end
        chk("R9 redirect_valid", {31'b0, redirect_valid}, {31'b0, k});
        chk("R9 tlb_inv", {31'b0, tlb_inv}, {31'b0, k});
        chk("R9 msr_clr", {31'b0, msr_clr}, {31'b0, k});
        if (k) chk("R9 redirect_pc", redirect_pc, t);
        chk("R5 isi_pc0_warn", {31'b0, isi_pc0_warn},
            {31'b0, k && t == 32'h400 && pc == 32'h0});
        chk("R8 mchk_me_err", {31'b0, mchk_me_err},
            {31'b0, k && t == 32'h200 && !m[12]});
        if (full) begin
            @(negedge clk);
            chk("R11 pulse drops", {28'b0, redirect_valid, tlb_inv, msr_clr, isi_pc0_warn | mchk_me_err}, '0);
            chk("R11 idle srr0", srr0, e_srr0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 srr0", srr0, '0);
        chk("R1 srr1", srr1, '0);
        chk("R1 dar", dar, '0);
        chk("R1 dsisr", dsisr, '0);
        chk("R1 pulses", {27'b0, redirect_valid, tlb_inv, msr_clr, isi_pc0_warn, mchk_me_err}, '0);
        rst_n = 1'b1;

        // R2 R10 R11: decoder sweep over the low code space
        for (int i = 0; i < 256; i++)
            do_req(32'(i) << 4, 32'hA5A5_0000 ^ 32'(i), 32'h1000 + 32'(i),
                   32'h4000 + 32'(i * 4), 32'h4004 + 32'(i * 4), 32'hFFFF_FFFF, 1'b0);
        // R10: aliases with upper bits set
        do_req(32'h0001_0200, 32'h1, 32'h2, 32'h100, 32'h104, 32'h1234, 1'b1);
        do_req(32'h8000_0C00, 32'h1, 32'h2, 32'h100, 32'h104, 32'h1234, 1'b1);
        do_req(32'h0000_0F00, 32'h1, 32'h2, 32'h100, 32'h104, 32'h1234, 1'b1);

        // R2..R9 per-type value checks across state patterns
        for (int p = 0; p < 4; p++) begin
            logic [31:0] m;
            logic [31:0] types [11];
            types = '{32'h200, 32'h300, 32'h400, 32'h500, 32'h700, 32'h800,
                      32'h900, 32'hC00, 32'hD00, 32'hE00, 32'hF20};
            case (p)
                0: m = 32'hFFFF_FFFF;
                1: m = 32'h0000_0000;
                2: m = 32'h5A3C_96E1;
                default: m = 32'hA5C3_6F1E;
            endcase
            foreach (types[j]) begin
                do_req(types[j], 32'h0000_0040 | (32'(p) << 20), 32'hDEAD_0000 + 32'(j),
                       32'h0010_0000 + 32'(j * 16), 32'h0010_0004 + 32'(j * 16), m, 1'b1);
            end
        end

        // R4: program with next bit set and clear
        do_req(32'h700, 32'h0001_0000, 32'h0, 32'h2000, 32'h2004, 32'h0000_1000, 1'b1);
        do_req(32'h700, 32'h0002_0000, 32'h0, 32'h3000, 32'h3004, 32'h0000_1000, 1'b1);
        // R5: instruction storage fault at address zero
        do_req(32'h400, 32'h4000_0000, 32'h0, 32'h0, 32'h4, 32'h0000_8000, 1'b1);
        // R8: machine check with checks enabled and disabled
        do_req(32'h200, 32'h0, 32'h0, 32'h500, 32'h504, 32'h0000_1000, 1'b1);
        do_req(32'h200, 32'h0, 32'h0, 32'h500, 32'h504, 32'h0000_0000, 1'b1);
        // R6: data storage then another type leaves fault registers alone
        do_req(32'h300, 32'h0200_0000, 32'hCAFE_F00D, 32'h600, 32'h604, 32'h0, 1'b1);
        do_req(32'h900, 32'h1111_1111, 32'h2222_2222, 32'h700, 32'h704, 32'h0, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule